// File: doc/BRIEF.md
# 8-bit ALU with Condition Code Register

This block computes 8-bit arithmetic, logic, shift, rotate and decimal-adjust results, plus a handful of 16-bit index operations. It keeps an 8-bit condition code register beside them. On every clock edge where `op_valid` is high, the result and the flag byte are registered together. Each operation class updates only the flags it owns. Some classes update every arithmetic flag, some update Z only, and some leave the flag byte untouched. The stored C and H bits feed back into add-with-carry, subtract-with-carry, the rotates and decimal adjust, so multi-byte arithmetic and multi-word shifts can be chained across several operations.

A sequencer drives one operation per cycle with operands on `opa` and `opb`. Eight-bit operations read the low byte of each operand and write a zero-extended byte to `result`. The flag byte holds, from bit 7 down to bit 0: stop-disable, X-mask, half-carry H, I-mask, negative N, zero Z, overflow V and carry C. This block never changes the three mask bits.

Top module: `alu8_ccr`

## Requirements
- R1: While `rst_n` is low, `result` is 0x0000 and `ccr` is 0xD0 (stop-disable, X-mask and I-mask set; all other bits clear). Outputs change on the clock edge that samples `op_valid` high, and are visible after that edge.
- R2: Bits 7, 6 and 4 of `ccr` stay at 1 after reset, whatever the operation.
- R3: Op codes 0 (add) and 1 (add with carry-in C) write the 8-bit sum zero-extended. They set C to the carry out of bit 7 and H to the carry out of bit 3. V is set on two's-complement overflow, N is taken from bit 7 of the result, and Z is set when the result byte is zero.
- R4: Op codes 2 (subtract), 3 (subtract with borrow-in C) and 4 (compare) compute opa−opb. C is set on unsigned borrow and V on signed overflow, and N and Z follow the difference. H is unchanged. Compare leaves `result` unchanged.
- R5: Op codes 5 (AND), 6 (OR) and 7 (XOR) write the logic result and update N and Z. They clear V and leave C and H unchanged.
- R6: Op code 8 (move) writes the low byte of opa, updates N and Z, clears V, and leaves C and H unchanged.
- R7: Op codes 9 (shift left, 0 in), 10 (shift right, 0 in), 11 (rotate left through C) and 12 (rotate right through C) set C to the bit shifted out. N and Z follow the result, V equals N xor C, and H is unchanged.
- R8: Op code 13 (decimal adjust) adds 0x06 when H was set or the low nibble of opa exceeds 9. It adds 0x60 when C was set or opa exceeds 0x99, and sets C exactly when that upper correction is applied. N and Z follow the result, V is cleared and H is unchanged.
- R9: Op codes 14 (16-bit increment) and 15 (16-bit decrement) write opa±1 modulo 2^16, set Z when the 16-bit result is zero, and leave every other flag unchanged.
- R10: Op code 16 (add low byte of opb to 16-bit opa, modulo 2^16) and op code 17 (16-bit move of opa) write `result` and leave `ccr` unchanged.
- R11: A cycle with `op_valid` low, or with an op code from 18 to 31, changes neither `result` nor `ccr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute `op` on this edge |
| op | input | 5 | Operation code |
| opa | input | 16 | First operand (low byte for 8-bit operations) |
| opb | input | 16 | Second operand (low byte used) |
| result | output | 16 | Registered result |
| ccr | output | 8 | Condition code register |

## Verification
The bound checker checks the per-class flag masks on every cycle. It confirms that the mask bits never move, that increment and decrement touch only Z, that index-add and move leave the flag byte alone, and that logic and move clear V while holding C. It also confirms that shifts leave V equal to N xor C, that compare does not write the result, and that idle cycles hold state. Only the bench's scenarios can show the actual values. These are the sums, borrows, half-carries, overflow boundaries at 0x7F/0x80, decimal-adjust corrections, and carry chaining through consecutive rotates and adds. The bench compares them against an independent integer model over directed and random sequences.

// File: rtl/alu8_ccr.sv
module alu8_ccr #(
  parameter int AW  = 16,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op,
  input  logic [AW-1:0]  opa,
  input  logic [AW-1:0]  opb,
  output logic [AW-1:0]  result,
  output logic [7:0]     ccr
);
  localparam int FC = 0, FV = 1, FZ = 2, FN = 3, FH = 5;
  localparam logic [7:0] CCR_RST = 8'hD0;

  localparam logic [OPW-1:0] K_ADD = 0,  K_ADC = 1,  K_SUB = 2,  K_SBC = 3,
                             K_CMP = 4,  K_AND = 5,  K_OR  = 6,  K_EOR = 7,
                             K_MOV = 8,  K_ASL = 9,  K_LSR = 10, K_ROL = 11,
                             K_ROR = 12, K_DAA = 13, K_INC = 14, K_DEC = 15,
                             K_ABX = 16, K_XFR = 17;

  logic [7:0] a8, b8;
  logic       cin;
  assign a8  = opa[7:0];
  assign b8  = opb[7:0];
  assign cin = ccr[FC];

  logic       use_c;
  logic [8:0] sum9, dif9;
  logic [4:0] half;
  assign use_c = (op == K_ADC) || (op == K_SBC);
  assign sum9  = {1'b0, a8} + {1'b0, b8} + {8'b0, use_c & cin};
  assign half  = {1'b0, a8[3:0]} + {1'b0, b8[3:0]} + {4'b0, use_c & cin};
  assign dif9  = {1'b0, a8} - {1'b0, b8} - {8'b0, use_c & cin};

  logic lo_fix, hi_fix;
  assign lo_fix = ccr[FH] || (a8[3:0] > 4'd9);
  assign hi_fix = cin || (a8 > 8'h99);

  logic [AW-1:0] nres;
  logic [7:0]    nccr, r8;
  logic          upd_nz, shv;

  always_comb begin
    nres   = result;
    nccr   = ccr;
    r8     = 8'h00;
    upd_nz = 1'b0;
    shv    = 1'b0;
    case (op)
      K_ADD, K_ADC: begin
        r8 = sum9[7:0]; upd_nz = 1'b1;
        nres = {{(AW-8){1'b0}}, r8};
        nccr[FC] = sum9[8];
        nccr[FH] = half[4];
        nccr[FV] = (a8[7] == b8[7]) && (r8[7] != a8[7]);
      end
      K_SUB, K_SBC, K_CMP: begin
        r8 = dif9[7:0]; upd_nz = 1'b1;
        if (op != K_CMP) nres = {{(AW-8){1'b0}}, r8};
        nccr[FC] = dif9[8];
        nccr[FV] = (a8[7] != b8[7]) && (r8[7] != a8[7]);
      end
      K_AND, K_OR, K_EOR, K_MOV: begin
        case (op)
          K_AND:   r8 = a8 & b8;
          K_OR:    r8 = a8 | b8;
          K_EOR:   r8 = a8 ^ b8;
          default: r8 = a8;
        endcase
        upd_nz = 1'b1;
        nres = {{(AW-8){1'b0}}, r8};
        nccr[FV] = 1'b0;
      end
      K_ASL, K_LSR, K_ROL, K_ROR: begin
        case (op)
          K_ASL:   begin r8 = {a8[6:0], 1'b0}; nccr[FC] = a8[7]; end
          K_LSR:   begin r8 = {1'b0, a8[7:1]}; nccr[FC] = a8[0]; end
          K_ROL:   begin r8 = {a8[6:0], cin};  nccr[FC] = a8[7]; end
          default: begin r8 = {cin, a8[7:1]};  nccr[FC] = a8[0]; end
        endcase
        upd_nz = 1'b1; shv = 1'b1;
        nres = {{(AW-8){1'b0}}, r8};
      end
      K_DAA: begin
        r8 = a8 + {hi_fix ? 4'h6 : 4'h0, lo_fix ? 4'h6 : 4'h0};
        upd_nz = 1'b1;
        nres = {{(AW-8){1'b0}}, r8};
        nccr[FC] = hi_fix;
        nccr[FV] = 1'b0;
      end
      K_INC, K_DEC: begin
        nres = (op == K_INC) ? opa + 1'b1 : opa - 1'b1;
        nccr[FZ] = (nres == '0);
      end
      K_ABX: nres = opa + {{(AW-8){1'b0}}, b8};
      K_XFR: nres = opa;
      default: ;
    endcase
    if (upd_nz) begin
      nccr[FN] = r8[7];
      nccr[FZ] = (r8 == 8'h00);
    end
    if (shv) nccr[FV] = nccr[FN] ^ nccr[FC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      ccr    <= CCR_RST;
    end else if (op_valid) begin
      result <= nres;
      ccr    <= nccr;
    end
  end
endmodule

// File: rtl/alu8_ccr_chk.sv
module alu8_ccr_chk #(
  parameter int AW  = 16,
  parameter int OPW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [OPW-1:0] op,
  input logic [AW-1:0]  result,
  input logic [7:0]     ccr
);
  logic is_add, is_logic, is_shift, is_idx, is_neutral, is_cmp, is_mov;
  assign is_add     = op_valid && (op == 0 || op == 1);
  assign is_cmp     = op_valid && (op == 4);
  assign is_logic   = op_valid && (op >= 5 && op <= 7);
  assign is_mov     = op_valid && (op == 8);
  assign is_shift   = op_valid && (op >= 9 && op <= 12);
  assign is_idx     = op_valid && (op == 14 || op == 15);
  assign is_neutral = op_valid && (op == 16 || op == 17);

  assert_mask_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ccr[7] && ccr[6] && ccr[4]);

  assert_add_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_add |=> (result[AW-1:8] == '0) && (ccr[2] == (result[7:0] == 8'h00)));

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> $stable(result));

  assert_logic_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> !ccr[1] && $stable(ccr[0]) && $stable(ccr[5]));

  assert_move_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mov |=> !ccr[1] && $stable(ccr[0]) && (ccr[3] == result[7]));

  assert_shift_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |=> (ccr[1] == (ccr[3] ^ ccr[0])));

  assert_index_z_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_idx |=> $stable(ccr[7:3]) && $stable(ccr[1:0]) && (ccr[2] == (result == '0)));

  assert_flag_neutral_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_neutral |=> $stable(ccr));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op >= 18) |=> $stable(ccr) && $stable(result));
endmodule

bind alu8_ccr alu8_ccr_chk #(.AW(AW), .OPW(OPW)) chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
  .result(result), .ccr(ccr)
);

// File: tb/alu8_ccr_test.sv
module alu8_ccr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] opa = '0, opb = '0;
  logic [15:0] result;
  logic [7:0]  ccr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [15:0] mr = 16'h0000;
  logic [7:0]  mf = 8'hD0;

  logic [15:0] q_res[$];
  logic [7:0]  q_ccr[$];
  string       q_tag[$];

  always #5ns clk = ~clk;

  alu8_ccr uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
                .opa(opa), .opb(opb), .result(result), .ccr(ccr));

  function automatic int s8(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string tag_of(logic [4:0] o, bit v);
    if (!v || o >= 18) return "R11";
    if (o <= 1)  return "R3";
    if (o <= 4)  return "R4";
    if (o <= 7)  return "R5";
    if (o == 8)  return "R6";
    if (o <= 12) return "R7";
    if (o == 13) return "R8";
    if (o <= 15) return "R9";
    return "R10";
  endfunction

  task automatic model(input logic [4:0] o, input logic [15:0] a, input logic [15:0] b);
    int ua, ub, c, t, sv;
    logic [7:0] r;
    bit nz;
    ua = int'(a[7:0]); ub = int'(b[7:0]); c = int'(mf[0]); nz = 0; r = 8'h00;
    case (o)
      0, 1: begin
        t  = ua + ub + ((o == 1) ? c : 0);
        sv = s8(ua) + s8(ub) + ((o == 1) ? c : 0);
        r = t[7:0]; nz = 1; mr = {8'h00, r};
        mf[0] = (t > 255);
        mf[5] = ((ua % 16) + (ub % 16) + ((o == 1) ? c : 0)) > 15;
        mf[1] = (sv > 127) || (sv < -128);
      end
      2, 3, 4: begin
        t  = ua - ub - ((o == 3) ? c : 0);
        sv = s8(ua) - s8(ub) - ((o == 3) ? c : 0);
        r = t[7:0]; nz = 1;
        if (o != 4) mr = {8'h00, r};
        mf[0] = (t < 0);
        mf[1] = (sv > 127) || (sv < -128);
      end
      5, 6, 7, 8: begin
        if (o == 5) r = a[7:0] & b[7:0];
        else if (o == 6) r = a[7:0] | b[7:0];
        else if (o == 7) r = a[7:0] ^ b[7:0];
        else r = a[7:0];
        nz = 1; mr = {8'h00, r}; mf[1] = 0;
      end
      9, 10, 11, 12: begin
        if (o == 9)       begin t = (ua * 2) % 256;         mf[0] = (ua >= 128); end
        else if (o == 10) begin t = ua / 2;                 mf[0] = (ua % 2) == 1; end
        else if (o == 11) begin t = (ua * 2 + c) % 256;     mf[0] = (ua >= 128); end
        else              begin t = ua / 2 + c * 128;       mf[0] = (ua % 2) == 1; end
        r = t[7:0]; nz = 1; mr = {8'h00, r};
      end
      13: begin
        t = 0;
        if (mf[5] || (ua % 16) > 9) t += 6;
        if (c == 1 || ua > 153) begin t += 96; mf[0] = 1; end else mf[0] = 0;
        t = (ua + t) % 256;
        r = t[7:0]; nz = 1; mr = {8'h00, r}; mf[1] = 0;
      end
      14: begin mr = a + 16'd1; mf[2] = (mr == 16'h0000); end
      15: begin mr = a - 16'd1; mf[2] = (mr == 16'h0000); end
      16: mr = a + {8'h00, b[7:0]};
      17: mr = a;
      default: ;
    endcase
    if (nz) begin
      mf[3] = r[7];
      mf[2] = (r == 8'h00);
      if (o >= 9 && o <= 12) mf[1] = mf[3] ^ mf[0];
    end
  endtask

  task automatic drive(input bit v, input logic [4:0] o, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op_valid = v; op = o; opa = a; opb = b;
    if (v) model(o, a, b);
    q_res.push_back(mr);
    q_ccr.push_back(mf);
    q_tag.push_back(tag_of(o, v));
  endtask

  always @(posedge clk) begin
    #1ns;
    if (q_res.size() > 0) begin
      logic [15:0] er;
      logic [7:0]  ef;
      string       tg;
      er = q_res.pop_front(); ef = q_ccr.pop_front(); tg = q_tag.pop_front();
      n_cmp++;
      if (result !== er || ccr !== ef) begin
        n_bad++;
        $display("FAIL %s: result=%h ccr=%h expected result=%h ccr=%h", tg, result, ccr, er, ef);
      end
      if (ccr[7] !== 1'b1 || ccr[6] !== 1'b1 || ccr[4] !== 1'b1) begin
        n_bad++;
        $display("FAIL R2: ccr=%h expected mask bits 7,6,4 set", ccr);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (result !== 16'h0000 || ccr !== 8'hD0) begin
      n_bad++;
      $display("FAIL R1: result=%h ccr=%h expected result=0000 ccr=d0", result, ccr);
    end
    rst_n = 1'b1;

    drive(1, 5'd0,  16'h007F, 16'h0001);  // R3 overflow, half carry
    drive(1, 5'd0,  16'h00FF, 16'h0001);  // R3 carry and zero
    drive(1, 5'd1,  16'h0010, 16'h0020);  // R3 carry-in used
    drive(1, 5'd2,  16'h0010, 16'h0020);  // R4 borrow
    drive(1, 5'd3,  16'h0080, 16'h0001);  // R4 borrow-in, signed overflow
    drive(1, 5'd4,  16'h0042, 16'h0042);  // R4 compare equal, result kept
    drive(1, 5'd5,  16'h00F0, 16'h000F);  // R5 AND zero
    drive(1, 5'd6,  16'h0080, 16'h0001);  // R5 OR negative
    drive(1, 5'd7,  16'h00AA, 16'h00AA);  // R5 XOR zero
    drive(1, 5'd8,  16'h0000, 16'h0000);  // R6 move zero
    drive(1, 5'd9,  16'h0080, 16'h0000);  // R7 shift left out
    drive(1, 5'd11, 16'h0001, 16'h0000);  // R7 rotate left takes C
    drive(1, 5'd12, 16'h0001, 16'h0000);  // R7 rotate right
    drive(1, 5'd10, 16'h0081, 16'h0000);  // R7 shift right
    drive(1, 5'd0,  16'h0015, 16'h0027);  // R8 setup 0x3C
    drive(1, 5'd13, 16'h003C, 16'h0000);  // R8 low fix -> 0x42
    drive(1, 5'd0,  16'h0099, 16'h0001);  // R8 setup 0x9A
    drive(1, 5'd13, 16'h009A, 16'h0000);  // R8 both fixes -> 0x00, C
    drive(1, 5'd0,  16'h0009, 16'h0009);  // R8 setup half carry
    drive(1, 5'd13, 16'h0012, 16'h0000);  // R8 H-driven fix -> 0x18
    drive(1, 5'd14, 16'hFFFF, 16'h0000);  // R9 wrap to zero
    drive(1, 5'd15, 16'h0001, 16'h0000);  // R9 down to zero
    drive(1, 5'd15, 16'h0000, 16'h0000);  // R9 wrap down
    drive(1, 5'd16, 16'h12F0, 16'hAB20);  // R10 index add
    drive(1, 5'd17, 16'hBEEF, 16'h0000);  // R10 move 16
    drive(0, 5'd0,  16'h1234, 16'h5678);  // R11 idle
    drive(1, 5'd25, 16'h1234, 16'h5678);  // R11 unused code
    for (int i = 0; i < 400; i++)
      drive(($urandom % 8) != 0, 5'($urandom % 20), 16'($urandom), 16'($urandom));
    drive(0, 5'd0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule